// File: doc/BRIEF.md
# Quotient Rounding Correction Unit

This block takes a quotient estimate from a multiplicative divider and turns it into a correctly rounded quotient. The estimate carries one bit more than the result and is within one unit of that extra bit of the exact quotient. The block multiplies the divisor by the estimate and compares the product with the shifted dividend. The sign of this residual shows whether the estimate lies above or below the true value. The block then steps the estimate down by one or leaves it as it is. That gives the exact truncation to the extra bit. The kept bit, the extra bit and the residual then decide the final rounding in the selected mode.

Operands are unsigned fixed-point. The dividend `num_i` must be below the divisor `den_i`, and `den_i` is nonzero. The exact scaled quotient is T = num·2^(QW+1)/den. The estimate `est_i` must satisfy |est_i − T| < 1. The result `q_o` is the quotient at QW fractional bits. It has one extra integer bit so that a round-up carry to 1.0 can be shown. A one-cycle `start_i` pulse launches the work, and a shift-add multiplier runs for a fixed number of cycles. `done_o` then pulses once, and the results stay on the outputs until the next completion.

Top module: `qrc_top`

## Requirements
- R1: While rst_ni is low, busy_o, done_o, q_o and inexact_o are all 0.
- R2: start_i is accepted only when busy_o is 0, and busy_o is 1 in the cycle after acceptance. A start_i seen while busy_o is 1 has no effect on the operation in progress or on its result.
- R3: done_o is a single-cycle pulse. It rises on the (QW+3)th rising edge after the edge that accepts start_i, and busy_o is 0 while done_o is 1.
- R4: If den·est > num·2^(QW+1), the truncated extended quotient is est−1. Otherwise it is est. The block never adds one to the estimate before rounding.
- R5: mode_i = 0 rounds to nearest with ties to even. Call the extended truncation t, with guard bit g = t[0], kept part t>>1, and sticky s = (residual ≠ 0). The result is rounded up when g=1 and either s=1 or bit 0 of the kept part is 1.
- R6: mode_i = 1 (toward zero) and mode_i = 3 (toward −inf) both return t>>1 for these positive operands.
- R7: mode_i = 2 (toward +inf) returns (t>>1)+1 whenever g or s is 1.
- R8: inexact_o is g OR s. When it is 0, q_o equals est/2.
- R9: q_o and inexact_o change only on a cycle where done_o is 1, and they hold their values until the next one.
- R10: A round-up that carries out of the QW fractional bits gives q_o = 2^QW, which is bit QW set and all other bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch one correction |
| mode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward −inf |
| num_i | input | W | Dividend, below den_i |
| den_i | input | W | Divisor, nonzero |
| est_i | input | QW+2 | Quotient estimate with QW+1 fractional bits |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| q_o | output | QW+1 | Rounded quotient: 1 integer bit, QW fractional bits |
| inexact_o | output | 1 | Result is not exact |

## Verification
The assertions check the handshake on every cycle:
- done_o is a one-cycle pulse and never coincides with busy_o.
- A start_i that arrives while busy leaves the latched operands alone.
- The outputs move only on completion.
- An exact result always equals half the estimate.

The multiplier's count stays live while it is busy. Only the bench scenarios can show that the residual sign picks the right step. The same holds for each mode's rounding, including ties with odd and even kept parts, for the carry to 1.0, and for the exact latency.

// File: rtl/qrc_pkg.sv
package qrc_pkg;
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_ZERO      = 2'd1,
    RND_UP        = 2'd2,
    RND_DOWN      = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/qrc_mul.sv
module qrc_mul #(
  parameter int AW = 8,
  parameter int BW = 8,
  localparam int PW = AW + BW,
  localparam int CW = $clog2(BW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic          done_o,
  output logic [PW-1:0] p_o
);
  logic [PW-1:0] acc_q, mc_q;
  logic [BW-1:0] mp_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      mc_q   <= '0;
      mp_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      acc_q  <= '0;
      mc_q   <= {{BW{1'b0}}, a_i};
      mp_q   <= b_i;
      cnt_q  <= CW'(BW);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (mp_q[0]) acc_q <= acc_q + mc_q;
      mc_q  <= mc_q << 1;
      mp_q  <= mp_q >> 1;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign p_o    = acc_q;

  assert_cnt_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q != '0);
endmodule

// File: rtl/qrc_round.sv
module qrc_round
  import qrc_pkg::*;
#(
  parameter int W  = 8,
  parameter int QW = 6,
  localparam int EW = QW + 2,
  localparam int PW = W + EW
) (
  input  rnd_mode_e     mode_i,
  input  logic [W-1:0]  num_i,
  input  logic [EW-1:0] est_i,
  input  logic [PW-1:0] prod_i,
  output logic [QW:0]   q_o,
  output logic          inexact_o
);
  logic [PW-1:0] lhs, diff;
  logic [EW-1:0] t;
  logic [QW:0]   kept;
  logic          neg, g, s, up;

  always_comb begin
    lhs  = {1'b0, num_i, {(QW+1){1'b0}}};
    neg  = prod_i > lhs;  // estimate above the true quotient
    diff = neg ? prod_i - lhs : lhs - prod_i;
    t    = neg ? est_i - 1'b1 : est_i;
    kept = t[EW-1:1];
    g    = t[0];
    s    = |diff;
    unique case (mode_i)
      RND_NEAR_EVEN: up = g & (s | kept[0]);
      RND_UP:        up = g | s;
      default:       up = 1'b0;
    endcase
    q_o       = kept + {{QW{1'b0}}, up};
    inexact_o = g | s;
  end
endmodule

// File: rtl/qrc_top.sv
module qrc_top
  import qrc_pkg::*;
#(
  parameter int W  = 8,
  parameter int QW = 6,
  localparam int EW = QW + 2,
  localparam int PW = W + EW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [W-1:0]  num_i,
  input  logic [W-1:0]  den_i,
  input  logic [EW-1:0] est_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [QW:0]   q_o,
  output logic          inexact_o
);
  logic          busy_q, done_q, inex_q, accept, mul_done;
  logic [W-1:0]  num_q;
  logic [EW-1:0] est_q;
  rnd_mode_e     mode_q;
  logic [QW:0]   q_q, rnd_q;
  logic          rnd_inex;
  logic [PW-1:0] prod;

  assign accept = start_i & ~busy_q;

  qrc_mul #(.AW(W), .BW(EW)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .a_i    (den_i),
    .b_i    (est_i),
    .done_o (mul_done),
    .p_o    (prod)
  );

  qrc_round #(.W(W), .QW(QW)) u_round (
    .mode_i   (mode_q),
    .num_i    (num_q),
    .est_i    (est_q),
    .prod_i   (prod),
    .q_o      (rnd_q),
    .inexact_o(rnd_inex)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      inex_q <= 1'b0;
      q_q    <= '0;
      num_q  <= '0;
      est_q  <= '0;
      mode_q <= RND_NEAR_EVEN;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        num_q  <= num_i;
        est_q  <= est_i;
        mode_q <= rnd_mode_e'(mode_i);
      end else if (busy_q && mul_done) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        q_q    <= rnd_q;
        inex_q <= rnd_inex;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign q_o       = q_q;
  assign inexact_o = inex_q;

  assert_ignore_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(num_q) && $stable(est_q) && $stable(mode_q)));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_exact_half_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !inexact_o) |-> ({q_o, 1'b0} == est_q));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(q_o) && $stable(inexact_o)));
endmodule

// File: tb/qrc_top_tb.sv
module qrc_top_tb;
  localparam int W   = 8;
  localparam int QW  = 6;
  localparam int EW  = QW + 2;
  localparam int LAT = QW + 4;  // negedges from drive to visible done_o

  // {mode[1:0], off[1:0], num[7:0], den[7:0]}; off=1 picks est above truth
  localparam logic [19:0] VEC [14] = '{
    {2'd0, 2'd0, 8'd5,   8'd128},  // tie, even kept
    {2'd0, 2'd0, 8'd7,   8'd128},  // tie, odd kept
    {2'd0, 2'd1, 8'd127, 8'd128},  // carry to 1.0
    {2'd0, 2'd1, 8'd100, 8'd200},  // exact
    {2'd1, 2'd1, 8'd1,   8'd3},
    {2'd3, 2'd0, 8'd2,   8'd3},
    {2'd2, 2'd1, 8'd2,   8'd3},
    {2'd2, 2'd0, 8'd5,   8'd128},
    {2'd1, 2'd1, 8'd200, 8'd201},
    {2'd2, 2'd0, 8'd200, 8'd201},
    {2'd0, 2'd1, 8'd77,  8'd155},
    {2'd3, 2'd1, 8'd127, 8'd128},
    {2'd0, 2'd0, 8'd0,   8'd1},
    {2'd2, 2'd1, 8'd254, 8'd255}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [W-1:0]  num_i = '0;
  logic [W-1:0]  den_i = 8'd1;
  logic [EW-1:0] est_i = '0;
  logic          busy_o, done_o, inexact_o;
  logic [QW:0]   q_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  qrc_top #(.W(W), .QW(QW)) u_dut (
    .clk_i, .rst_ni, .start_i, .mode_i, .num_i, .den_i, .est_i,
    .busy_o, .done_o, .q_o, .inexact_o
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // reference from the requirement arithmetic
  task automatic model(input int m, input int n, input int d, input int off,
                       output int est, output int q, output int inex, output bit corr);
    int numx, t, rem, kept, g, s, up;
    numx = n << (QW + 1);
    t    = numx / d;
    rem  = numx % d;
    corr = (off != 0) && (rem != 0);
    est  = corr ? t + 1 : t;
    kept = t >> 1;
    g    = t & 1;
    s    = (rem != 0) ? 1 : 0;
    case (m)
      0:       up = g & (s | (kept & 1));
      2:       up = g | s;
      default: up = 0;
    endcase
    q    = kept + up;
    inex = g | s;
  endtask

  task automatic launch(input int m, input int n, input int d, input int est);
    @(negedge clk_i);
    mode_i  = 2'(m);
    num_i   = W'(n);
    den_i   = W'(d);
    est_i   = EW'(est);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done_o && lat < 60) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  initial begin
    int est, q, inex, lat;
    bit corr;
    string tag;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 q", q_o, 0);
    chk("R1 inexact", inexact_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 14; i++) begin
      model(VEC[i][19:18], VEC[i][15:8], VEC[i][7:0], VEC[i][17:16], est, q, inex, corr);
      launch(VEC[i][19:18], VEC[i][15:8], VEC[i][7:0], est);
      wait_done(lat);
      case (VEC[i][19:18])
        2'd0:    tag = corr ? "R4 R5" : "R5";
        2'd2:    tag = corr ? "R4 R7" : "R7";
        default: tag = corr ? "R4 R6" : "R6";
      endcase
      chk($sformatf("%s q vec%0d", tag, i), q_o, q);
      chk($sformatf("R8 inexact vec%0d", i), inexact_o, inex);
      if (i == 2) chk("R10 carry q", q_o, 1 << QW);
    end

    // R3 latency, pulse width; R2 busy after accept
    model(0, 77, 155, 1, est, q, inex, corr);
    launch(0, 77, 155, est);
    chk("R2 busy after accept", busy_o, 1);
    wait_done(lat);
    chk("R3 latency", lat, LAT);
    chk("R3 idle at done", busy_o, 0);
    @(negedge clk_i);
    chk("R3 single pulse", done_o, 0);

    // R9 hold with changing inputs and no start
    num_i = 8'd3; den_i = 8'd7; est_i = '1; mode_i = 2'd2;
    repeat (5) @(negedge clk_i);
    chk("R9 q held", q_o, q);
    chk("R9 inexact held", inexact_o, inex);

    // R2 start while busy is ignored
    model(1, 200, 201, 1, est, q, inex, corr);
    launch(1, 200, 201, est);
    mode_i = 2'd2; num_i = 8'd5; den_i = 8'd128; est_i = 8'd5;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(lat);
    chk("R2 ignored start q", q_o, q);
    chk("R2 ignored start inexact", inexact_o, inex);
    chk("R2 latency unchanged", lat, LAT - 1);

    // R4 direction: same operands, estimate below vs above truth
    model(1, 1, 3, 0, est, q, inex, corr);
    launch(1, 1, 3, est);
    wait_done(lat);
    chk("R4 low estimate", q_o, q);
    model(1, 1, 3, 1, est, q, inex, corr);
    launch(1, 1, 3, est);
    wait_done(lat);
    chk("R4 high estimate", q_o, q);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule